// File: doc/BRIEF.md
# Watchdog Timer with Protected Disable

This block is a watchdog timer that raises a one-cycle system reset pulse when software fails to restart it within a selectable period. It runs entirely on the watchdog oscillator clock. A three-bit period select chooses one of eight timeouts, each a power of two. Every restart strobe clears the running count, and software normally issues one well inside the chosen period.

Software reaches the block through an 8-bit control register. The register holds an enable bit, a disarm-window bit and the period select. Turning the watchdog on is always allowed. Turning it off takes a timed two-step sequence. The first write sets the disarm-window bit and the enable bit together, which opens a window of four clock cycles. A second write that clears the enable bit only takes effect if the block samples it while that window is still open. The hardware closes the window by itself, so a single stray write cannot stop the watchdog.

Top module: `wdog_guard`

## Requirements
- R1: After reset, rd_data reads 0x00, pulse_rst is low and the watchdog is disabled.
- R2: rd_data bits 7..5 always read zero. Bit 4 is the disarm-window flag, bit 3 is enable, and bits 2..0 are the period select. Every write loads bits 2..0 into the period select.
- R3: A write with bit 3 = 1 sets enable at once, whatever state the window is in.
- R4: A write with bit 3 = 0 while the window flag reads 0 leaves enable unchanged.
- R5: A write with bits 4 and 3 both 1 sets the window flag. The flag then reads 1 for exactly four cycles after that write and returns to 0 by itself. Writing bit 4 = 1 together with bit 3 = 0 does not set the flag.
- R6: A write with bit 3 = 0 sampled in any of the four window cycles clears enable. The same write one cycle later has no effect.
- R7: While enabled and not restarted, pulse_rst rises 2^(BASE_EXP+sel) cycles after the clock edge that enabled the block. It then repeats every 2^(BASE_EXP+sel) cycles.
- R8: pulse_rst is high for exactly one cycle, and counting starts again from zero after each timeout.
- R9: A restart strobe while enabled clears the count. The next pulse then comes 2^(BASE_EXP+sel) cycles after the edge that sampled the strobe.
- R10: While disabled, pulse_rst stays low and a restart strobe has no effect. Counting starts from zero when the block is enabled again.
- R11: If the period select is lowered while the count is already at or beyond the new limit, the timeout fires on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write data |
| kick | input | 1 | Restart strobe, clears the count |
| rd_data | output | 8 | Control register read value |
| pulse_rst | output | 1 | One-cycle system reset pulse |

## Verification
A wrong period counter appears at pulse_rst as a pulse that comes early or late by some number of cycles. It therefore shows up only at the first timeout, which can be up to one full period after the fault. A broken window counter or enable logic shows at rd_data on the very next cycle: the window flag stays up too long or drops too early, or a disabling write takes effect when it should not, or fails to. The bench compares rd_data and pulse_rst every cycle against its own model. Timing faults are therefore pinned to the exact cycle, while control faults are pinned to the cycle after the write.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int SEL_W    = 3;
  localparam int BIT_TDIS = 4;
  localparam int BIT_EN   = 3;

  typedef struct packed {
    logic             tdis;
    logic             en;
    logic [SEL_W-1:0] sel;
  } wdg_ctrl_t;
endpackage

// File: rtl/wdg_window.sv
module wdg_window #(
  parameter int WIN_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  output logic open
);
  localparam int WW = (WIN_CYC > 1) ? $clog2(WIN_CYC) : 1;
  localparam logic [WW-1:0] LOAD = WW'(WIN_CYC - 1);

  logic [WW-1:0] left;

  always_ff @(posedge clk) begin
    if (rst) begin
      open <= 1'b0;
      left <= '0;
    end else if (arm) begin
      open <= 1'b1;
      left <= LOAD;
    end else if (open) begin
      if (left == '0) open <= 1'b0;
      else            left <= left - 1'b1;
    end
  end
endmodule

// File: rtl/wdg_ctrl_reg.sv
module wdg_ctrl_reg
  import wdg_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              win_open,
  output logic              arm,
  output wdg_ctrl_t         ctrl
);
  logic en_q;
  logic [SEL_W-1:0] sel_q;

  assign arm = wr_en & wr_data[BIT_TDIS] & wr_data[BIT_EN];

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= 1'b0;
      sel_q <= '0;
    end else if (wr_en) begin
      sel_q <= wr_data[SEL_W-1:0];
      if (wr_data[BIT_EN])  en_q <= 1'b1;
      else if (win_open)    en_q <= 1'b0;
    end
  end

  always_comb begin
    ctrl.tdis = win_open;
    ctrl.en   = en_q;
    ctrl.sel  = sel_q;
  end
endmodule

// File: rtl/wdg_period_cnt.sv
module wdg_period_cnt #(
  parameter int BASE_EXP = 14,
  parameter int SEL_W    = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [SEL_W-1:0] sel,
  input  logic             kick,
  output logic             pulse
);
  localparam int NSEL  = 1 << SEL_W;
  localparam int CNT_W = BASE_EXP + NSEL - 1;

  logic [CNT_W-1:0] lim [NSEL];
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cur_lim;

  for (genvar g = 0; g < NSEL; g++) begin : g_lim
    assign lim[g] = {CNT_W{1'b1}} >> (NSEL - 1 - g);
  end

  assign cur_lim = lim[sel];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      pulse <= 1'b0;
    end else begin
      pulse <= 1'b0;
      if (!en || kick) begin
        cnt <= '0;
      end else if (cnt >= cur_lim) begin
        cnt   <= '0;
        pulse <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/wdog_guard.sv
module wdog_guard
  import wdg_pkg::*;
#(
  parameter int BASE_EXP = 14,
  parameter int WIN_CYC  = 4,
  parameter int DATA_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              kick,
  output logic [DATA_W-1:0] rd_data,
  output logic              pulse_rst
);
  logic      arm;
  logic      win_open;
  wdg_ctrl_t ctrl;

  wdg_window #(.WIN_CYC(WIN_CYC)) u_win (
    .clk (clk),
    .rst (rst),
    .arm (arm),
    .open(win_open)
  );

  wdg_ctrl_reg #(.DATA_W(DATA_W)) u_reg (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .win_open(win_open),
    .arm     (arm),
    .ctrl    (ctrl)
  );

  wdg_period_cnt #(.BASE_EXP(BASE_EXP), .SEL_W(SEL_W)) u_cnt (
    .clk  (clk),
    .rst  (rst),
    .en   (ctrl.en),
    .sel  (ctrl.sel),
    .kick (kick),
    .pulse(pulse_rst)
  );

  always_comb begin
    rd_data              = '0;
    rd_data[BIT_TDIS]    = ctrl.tdis;
    rd_data[BIT_EN]      = ctrl.en;
    rd_data[SEL_W-1:0]   = ctrl.sel;
  end
endmodule

// File: rtl/wdog_guard_chk.sv
module wdog_guard_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic              kick,
  input logic [DATA_W-1:0] rd_data,
  input logic              pulse_rst
);
  AST_SEL_LOAD: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> rd_data[2:0] == $past(wr_data[2:0])); // R2
  AST_SET_EN: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data[3]) |=> rd_data[3]); // R3
  AST_LOCKED_KEEP: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_data[3] && !rd_data[4] && rd_data[3]) |=> rd_data[3]); // R4
  AST_ARM_OPENS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data[4] && wr_data[3]) |=> rd_data[4]); // R5
  AST_FLAG_SOURCE: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_data[4]) |-> $past(wr_en && wr_data[4] && wr_data[3])); // R5
  AST_OPEN_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_data[3] && rd_data[4]) |=> !rd_data[3]); // R6
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    pulse_rst |=> !pulse_rst); // R8
  AST_KICK_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (rd_data[3] && kick) |=> !pulse_rst); // R9
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
    !rd_data[3] |=> !pulse_rst); // R10
endmodule

bind wdog_guard wdog_guard_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .wr_en    (wr_en),
  .wr_data  (wr_data),
  .kick     (kick),
  .rd_data  (rd_data),
  .pulse_rst(pulse_rst)
);

// File: tb/wdog_guard_test.sv
`timescale 1ns/1ps
module wdog_guard_test;
  localparam int BE = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       kick = 1'b0;
  logic [7:0] rd_data;
  logic       pulse_rst;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  string tag = "R1";

  always #2.5 clk = ~clk;

  wdog_guard #(.BASE_EXP(BE), .WIN_CYC(4), .DATA_W(8)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .kick(kick), .rd_data(rd_data), .pulse_rst(pulse_rst)
  );

  // reference model built from the requirements
  logic        m_en = 1'b0;
  logic [2:0]  m_sel = 3'd0;
  int          m_left = 0;
  int          m_cnt = 0;
  logic        m_pulse = 1'b0;

  function automatic int period(input logic [2:0] s);
    return 1 << (BE + int'(s));
  endfunction

  function automatic logic [7:0] m_rd();
    return {3'b000, (m_left > 0), m_en, m_sel};
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_en <= 1'b0; m_sel <= 3'd0; m_left <= 0; m_cnt <= 0; m_pulse <= 1'b0;
    end else begin
      if (wr_en) begin
        m_sel <= wr_data[2:0];
        if (wr_data[3]) m_en <= 1'b1;
        else if (m_left > 0) m_en <= 1'b0;
      end
      if (wr_en && wr_data[4] && wr_data[3]) m_left <= 4;
      else if (m_left > 0) m_left <= m_left - 1;
      m_pulse <= 1'b0;
      if (!m_en || kick) m_cnt <= 0;
      else if (m_cnt >= period(m_sel) - 1) begin m_cnt <= 0; m_pulse <= 1'b1; end
      else m_cnt <= m_cnt + 1;
    end
  end

  task automatic chk(input string t, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at cycle %0d", t, act, exp, cyc);
    end
  endtask

  task automatic step(input logic w, input logic [7:0] d, input logic k);
    @(negedge clk);
    chk({tag, " rd_data"}, int'(rd_data), int'(m_rd()));
    chk({tag, " pulse_rst"}, int'(pulse_rst), int'(m_pulse));
    wr_en = w; wr_data = d; kick = k;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 8'h00, 1'b0);
  endtask

  task automatic wait_pulse(output int n);
    n = 0;
    do begin step(1'b0, 8'h00, 1'b0); n++; end while (!pulse_rst && n < 5000);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
      $finish;
    end
  end

  initial begin
    int n;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    tag = "R1";
    @(negedge clk);
    chk("R1 rd_data", int'(rd_data), 0);
    chk("R1 pulse_rst", int'(pulse_rst), 0);
    idle(40);
    chk("R1 quiet", int'(pulse_rst), 0);

    // R3 enable without unlock, sel 0
    tag = "R3";
    step(1'b1, 8'h08, 1'b0);
    step(1'b0, 8'h00, 1'b0);
    chk("R3 en set", int'(rd_data), 8'h08);

    // R7 / R8 pulse spacing and width
    tag = "R7";
    wait_pulse(n);
    wait_pulse(n);
    chk("R7 interval sel0", n, 16);
    tag = "R8";
    step(1'b0, 8'h00, 1'b0);
    chk("R8 width", int'(pulse_rst), 0);

    // R9 kick restart
    tag = "R9";
    idle(5);
    step(1'b0, 8'h00, 1'b1);
    wait_pulse(n);
    chk("R9 after kick", n, 17);

    // R4 locked clear ignored, R2 select loads
    tag = "R4";
    step(1'b1, 8'h02, 1'b0);
    step(1'b0, 8'h00, 1'b0);
    chk("R4 en kept", int'(rd_data), 8'h0A);
    tag = "R2";
    step(1'b1, 8'hE9, 1'b0);
    step(1'b0, 8'h00, 1'b0);
    chk("R2 reserved zero", int'(rd_data), 8'h09);

    // R5 window flag duration, and bit4 alone does not arm
    tag = "R5";
    step(1'b1, 8'h10, 1'b0);
    step(1'b0, 8'h00, 1'b0);
    chk("R5 bit4 alone", int'(rd_data), 8'h08);
    step(1'b1, 8'h18, 1'b0);
    for (int i = 0; i < 4; i++) begin
      step(1'b0, 8'h00, 1'b0);
      chk("R5 flag up", int'(rd_data[4]), 1);
    end
    step(1'b0, 8'h00, 1'b0);
    chk("R5 flag down", int'(rd_data[4]), 0);

    // R6 last-cycle clear works; one cycle late fails
    tag = "R6";
    step(1'b1, 8'h18, 1'b0);
    idle(3);
    step(1'b1, 8'h00, 1'b0);
    step(1'b0, 8'h00, 1'b0);
    chk("R6 clear in window", int'(rd_data[3]), 0);
    idle(6);
    step(1'b1, 8'h18, 1'b0);
    idle(4);
    step(1'b1, 8'h00, 1'b0);
    step(1'b0, 8'h00, 1'b0);
    chk("R6 late clear", int'(rd_data[3]), 1);
    step(1'b1, 8'h18, 1'b0);
    step(1'b1, 8'h01, 1'b0);
    step(1'b0, 8'h00, 1'b0);
    chk("R6 first window cycle", int'(rd_data), 8'h11);

    // R10 disabled: no pulse, kick no effect, fresh start on enable
    tag = "R10";
    n = 0;
    for (int i = 0; i < 300; i++) begin
      step(1'b0, 8'h00, (i % 37) == 0);
      if (pulse_rst) n++;
    end
    chk("R10 no pulse", n, 0);
    step(1'b1, 8'h08, 1'b0);
    wait_pulse(n);
    chk("R10 fresh count", n, 17);

    // R11 lower select past limit
    tag = "R11";
    step(1'b1, 8'h0B, 1'b0);
    idle(60);
    step(1'b1, 8'h08, 1'b0);
    step(1'b0, 8'h00, 1'b0);
    chk("R11 not yet", int'(pulse_rst), 0);
    step(1'b0, 8'h00, 1'b0);
    chk("R11 fires", int'(pulse_rst), 1);

    // random mix, compared cycle by cycle
    tag = "R2/R7";
    for (int i = 0; i < 30000; i++) begin
      int r = int'($urandom % 1000);
      if (r < 25) step(1'b1, 8'($urandom) & 8'hFB, 1'b0);
      else if (r < 35) begin
        step(1'b1, 8'h18 | 8'($urandom % 4), 1'b0);
        idle(int'($urandom % 6));
        step(1'b1, 8'($urandom % 4), 1'b0);
      end else if (r < 45) step(1'b0, 8'h00, 1'b1);
      else step(1'b0, 8'h00, 1'b0);
    end

    summary();
    $finish;
  end
endmodule